// File: doc/BRIEF.md
# Pattern Streamer Output Stage

This block is the output-clock half of a pattern streamer. It pulls decoded elements from the read port of a first-word-fall-through FIFO and turns them into a parallel output word with a data-valid qualifier, a strobe, a completion flag and an underrun flag. A read is requested only while the upstream trigger logic reports activation and the gate is open. Both of these levels are already synchronous to the output clock.

Each FIFO element carries a 2-bit kind tag alongside its data. The kind selects one of four actions: a strobed data update, a silent data update, end of stream, or a retrigger marker. Until the stage has registered trigger activation, the output word shows a programmable preset value. The two terminal conditions, clean completion and underrun, are sticky. Once either one is set, the stage issues no further reads until a synchronous reset.

Top module: `pso_top`

## Requirements
- R1: `fifo_rd` is high in a cycle exactly when `trig_active` and `gate_en` are both high, reset is low, and neither `done` nor `buf_err` is set. It is combinational, so it is visible in the same cycle.
- R2: Until a clock edge has sampled `trig_active` high after reset, `q_word` equals the `init_value` input and follows any change of that input.
- R3: A read of a non-empty element with kind 2'b00 loads its data into `q_word` and raises `q_valid` for the following cycle.
- R4: A read of a non-empty element with kind 2'b01 loads its data into `q_word` and leaves `q_valid` low.
- R5: `q_strobe` is high only while `q_valid` is high and the clock is in its low phase. It is low throughout the high phase.
- R6: A read of a non-empty element with kind 2'b10 sets `done` from the next cycle on. It leaves `q_word` unchanged and `q_valid` low.
- R7: A read while `fifo_empty` is high sets `buf_err` from the next cycle on and leaves `q_word` unchanged.
- R8: `done` and `buf_err` stay set until reset, are never both high, and hold `fifo_rd` low while either is set.
- R9: While the gate is closed or the trigger level is low, no reads happen. `q_word` holds its last value and `q_valid` is low. Reopening the gate continues with the next element and does not restart the stream.
- R10: A read of a non-empty element with kind 2'b11 pulses `retrig_pulse` for exactly one cycle. It leaves `q_word` unchanged and `q_valid` low.
- R11: While and right after reset, `q_valid`, `q_strobe`, `done`, `buf_err` and `retrig_pulse` are low, and `q_word` shows `init_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| init_value | input | DATA_W | Preset word shown before the trigger is captured |
| trig_active | input | 1 | Trigger-activated level, output domain |
| gate_en | input | 1 | Gate-open level, output domain |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_data | input | DATA_W | Head element data (show-ahead) |
| fifo_tag | input | 2 | Head element kind |
| fifo_rd | output | 1 | FIFO read request, pops the head at the clock edge |
| q_word | output | DATA_W | Parallel output word |
| q_valid | output | 1 | Qualifier for a strobed data update |
| q_strobe | output | 1 | Strobe in the clock-low phase of a valid cycle |
| done | output | 1 | Sticky: terminator read cleanly |
| buf_err | output | 1 | Sticky: read attempted on an empty FIFO |
| retrig_pulse | output | 1 | One-cycle pulse on a retrigger element |

## Verification
The bench targets the first read after trigger activation. There, a design that let the preset load win over the data load would show the preset instead of the element. It also checks that silent and retrigger elements leave the qualifier low; a design that decoded the tag loosely would strobe on them. After a terminator or an underrun, it presents more elements and confirms that none are consumed, since a missing stop would set both flags or keep moving the word. It also samples the strobe in both clock phases, which catches a strobe registered or qualified with the wrong polarity.

// File: rtl/pso_pkg.sv
package pso_pkg;
  typedef enum logic [1:0] {
    ELEM_DATA   = 2'b00,
    ELEM_QUIET  = 2'b01,
    ELEM_END    = 2'b10,
    ELEM_RETRIG = 2'b11
  } elem_kind_e;

  localparam int unsigned KIND_W = 2;
endpackage

// File: rtl/pso_read_ctrl.sv
module pso_read_ctrl
  import pso_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_active,
  input  logic              gate_en,
  input  logic              fifo_empty,
  input  logic [KIND_W-1:0] fifo_tag,
  output logic              fifo_rd,
  output logic              word_load,
  output logic              done,
  output logic              buf_err
);
  logic       done_r, err_r;
  elem_kind_e kind;

  assign kind    = elem_kind_e'(fifo_tag);
  // Terminal states freeze the read side until reset
  assign fifo_rd = trig_active & gate_en & ~rst & ~done_r & ~err_r;
  assign word_load = fifo_rd & ~fifo_empty &
                     ((kind == ELEM_DATA) || (kind == ELEM_QUIET));

  always_ff @(posedge clk) begin
    if (rst) begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
    end else if (fifo_rd) begin
      if (fifo_empty)              err_r  <= 1'b1;
      else if (kind == ELEM_END)   done_r <= 1'b1;
    end
  end

  assign done    = done_r;
  assign buf_err = err_r;
endmodule

// File: rtl/pso_word_path.sv
module pso_word_path #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] init_value,
  input  logic              trig_active,
  input  logic              word_load,
  input  logic [DATA_W-1:0] fifo_data,
  output logic [DATA_W-1:0] q_word
);
  logic              trig_seen;
  logic [DATA_W-1:0] word_r;

  always_ff @(posedge clk) begin
    if (rst) trig_seen <= 1'b0;
    else if (trig_active) trig_seen <= 1'b1;
  end

  // A data load outranks the preset so the first element after
  // activation lands on the same edge that captures the trigger
  always_ff @(posedge clk) begin
    if (rst)             word_r <= '0;
    else if (word_load)  word_r <= fifo_data;
    else if (!trig_seen) word_r <= init_value;
  end

  assign q_word = trig_seen ? word_r : init_value;
endmodule

// File: rtl/pso_qualifier.sv
module pso_qualifier
  import pso_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_rd,
  input  logic              fifo_empty,
  input  logic [KIND_W-1:0] fifo_tag,
  output logic              q_valid,
  output logic              q_strobe,
  output logic              retrig_pulse
);
  logic       valid_r, retrig_r, good_read;
  elem_kind_e kind;

  assign kind      = elem_kind_e'(fifo_tag);
  assign good_read = fifo_rd & ~fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r  <= 1'b0;
      retrig_r <= 1'b0;
    end else begin
      valid_r  <= good_read & (kind == ELEM_DATA);
      retrig_r <= good_read & (kind == ELEM_RETRIG);
    end
  end

  assign q_valid      = valid_r;
  assign q_strobe     = valid_r & ~clk;
  assign retrig_pulse = retrig_r;
endmodule

// File: rtl/pso_top.sv
module pso_top
  import pso_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] init_value,
  input  logic              trig_active,
  input  logic              gate_en,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [1:0]        fifo_tag,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] q_word,
  output logic              q_valid,
  output logic              q_strobe,
  output logic              done,
  output logic              buf_err,
  output logic              retrig_pulse
);
  logic word_load;

  pso_read_ctrl u_ctrl (
    .clk(clk), .rst(rst), .trig_active(trig_active), .gate_en(gate_en),
    .fifo_empty(fifo_empty), .fifo_tag(fifo_tag), .fifo_rd(fifo_rd),
    .word_load(word_load), .done(done), .buf_err(buf_err)
  );

  pso_word_path #(.DATA_W(DATA_W)) u_word (
    .clk(clk), .rst(rst), .init_value(init_value), .trig_active(trig_active),
    .word_load(word_load), .fifo_data(fifo_data), .q_word(q_word)
  );

  pso_qualifier u_qual (
    .clk(clk), .rst(rst), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
    .fifo_tag(fifo_tag), .q_valid(q_valid), .q_strobe(q_strobe),
    .retrig_pulse(retrig_pulse)
  );
endmodule

// File: rtl/pso_checker.sv
module pso_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_active,
  input logic              gate_en,
  input logic              fifo_empty,
  input logic [DATA_W-1:0] fifo_data,
  input logic [1:0]        fifo_tag,
  input logic              fifo_rd,
  input logic [DATA_W-1:0] q_word,
  input logic              q_valid,
  input logic              done,
  input logic              buf_err,
  input logic              retrig_pulse
);
  // R1
  rd_needs_trig_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (trig_active && gate_en));
  // R3
  data_read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && !fifo_empty && fifo_tag == 2'b00) |=> (q_valid && q_word == $past(fifo_data)));
  // R9
  valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> $past(fifo_rd));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    buf_err |=> buf_err);
  // R8
  terminal_stops_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (done || buf_err) |-> !fifo_rd);
  // R8
  terminal_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && buf_err));
  // R10
  retrig_source_chk: assert property (@(posedge clk) disable iff (rst)
    retrig_pulse |-> $past(fifo_rd && !fifo_empty && fifo_tag == 2'b11));
  // R7
  empty_read_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && fifo_empty) |=> (buf_err && !q_valid));
endmodule

bind pso_top pso_checker #(.DATA_W(DATA_W)) u_pso_chk (
  .clk(clk), .rst(rst), .trig_active(trig_active), .gate_en(gate_en),
  .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_tag(fifo_tag),
  .fifo_rd(fifo_rd), .q_word(q_word), .q_valid(q_valid), .done(done),
  .buf_err(buf_err), .retrig_pulse(retrig_pulse)
);

// File: tb/pso_top_test.sv
`timescale 1ns/100ps
module pso_top_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] init_value = 16'hA5A5;
  logic          trig_active = 1'b0, gate_en = 1'b0, fifo_empty = 1'b1;
  logic [DW-1:0] fifo_data = '0;
  logic [1:0]    fifo_tag = 2'b00;
  logic          fifo_rd, q_valid, q_strobe, done, buf_err, retrig_pulse;
  logic [DW-1:0] q_word;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pso_top #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .init_value(init_value), .trig_active(trig_active),
    .gate_en(gate_en), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_tag(fifo_tag), .fifo_rd(fifo_rd), .q_word(q_word), .q_valid(q_valid),
    .q_strobe(q_strobe), .done(done), .buf_err(buf_err), .retrig_pulse(retrig_pulse)
  );

  typedef struct packed {
    logic trig; logic gate; logic empty; logic [1:0] tag; logic [15:0] data;
    logic rd; logic [15:0] word; logic valid; logic dn; logic er; logic rt;
  } vec_t;

  // Steps run in order after reset; init_value stays 16'hA5A5
  localparam vec_t VEC [11] = '{
    '{1'b0,1'b1,1'b0,2'b00,16'h1111, 1'b0,16'hA5A5,1'b0,1'b0,1'b0,1'b0}, // R2 no trig
    '{1'b1,1'b0,1'b0,2'b00,16'h2222, 1'b0,16'hA5A5,1'b0,1'b0,1'b0,1'b0}, // R9 gate shut
    '{1'b1,1'b1,1'b0,2'b00,16'h1234, 1'b1,16'h1234,1'b1,1'b0,1'b0,1'b0}, // R3
    '{1'b1,1'b1,1'b0,2'b01,16'h5678, 1'b1,16'h5678,1'b0,1'b0,1'b0,1'b0}, // R4
    '{1'b1,1'b0,1'b0,2'b00,16'h9999, 1'b0,16'h5678,1'b0,1'b0,1'b0,1'b0}, // R9 hold
    '{1'b1,1'b1,1'b0,2'b11,16'h7777, 1'b1,16'h5678,1'b0,1'b0,1'b0,1'b1}, // R10
    '{1'b1,1'b1,1'b0,2'b00,16'hABCD, 1'b1,16'hABCD,1'b1,1'b0,1'b0,1'b0}, // R9 resume
    '{1'b0,1'b1,1'b0,2'b00,16'h4321, 1'b0,16'hABCD,1'b0,1'b0,1'b0,1'b0}, // R1 trig low
    '{1'b1,1'b1,1'b0,2'b10,16'h0F0F, 1'b1,16'hABCD,1'b0,1'b1,1'b0,1'b0}, // R6
    '{1'b1,1'b1,1'b1,2'b00,16'h0000, 1'b0,16'hABCD,1'b0,1'b1,1'b0,1'b0}, // R8 no err
    '{1'b1,1'b1,1'b0,2'b00,16'h3333, 1'b0,16'hABCD,1'b0,1'b1,1'b0,1'b0}  // R8 no read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic t, input logic g, input logic e,
                       input logic [1:0] k, input logic [15:0] d);
    trig_active = t; gate_en = g; fifo_empty = e; fifo_tag = k; fifo_data = d;
  endtask

  task automatic next_cycle();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    drive(1'b0, 1'b0, 1'b1, 2'b00, '0);
    rst = 1'b1;
    repeat (3) next_cycle();
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R11 reset state
    check("R11 q_valid", q_valid, 0);
    check("R11 done", done, 0);
    check("R11 buf_err", buf_err, 0);
    check("R11 retrig", retrig_pulse, 0);
    check("R11 q_strobe", q_strobe, 0);
    check("R11 q_word", q_word, 16'hA5A5);

    for (int i = 0; i < 11; i++) begin
      drive(VEC[i].trig, VEC[i].gate, VEC[i].empty, VEC[i].tag, VEC[i].data);
      #0.5;
      check($sformatf("R1 rd step %0d", i), fifo_rd, VEC[i].rd);
      next_cycle();
      check($sformatf("R3/R4/R9 word step %0d", i), q_word, VEC[i].word);
      check($sformatf("R3 valid step %0d", i), q_valid, VEC[i].valid);
      check($sformatf("R5 strobe low phase step %0d", i), q_strobe, VEC[i].valid);
      check($sformatf("R6 done step %0d", i), done, VEC[i].dn);
      check($sformatf("R7 err step %0d", i), buf_err, VEC[i].er);
      check($sformatf("R10 retrig step %0d", i), retrig_pulse, VEC[i].rt);
    end

    // R2: preset follows init_value before trigger capture
    do_reset();
    init_value = 16'h0001;
    #0.5;
    check("R2 preset tracks input", q_word, 16'h0001);

    // R7: underrun as the first read
    drive(1'b1, 1'b1, 1'b1, 2'b00, '0);
    #0.5;
    check("R7 rd on empty", fifo_rd, 1);
    next_cycle();
    check("R7 buf_err set", buf_err, 1);
    check("R7 word unchanged", q_word, 16'h0001);
    check("R7 no valid", q_valid, 0);
    drive(1'b1, 1'b1, 1'b0, 2'b10, 16'h5555);
    #0.5;
    check("R8 rd blocked after err", fifo_rd, 0);
    next_cycle();
    check("R8 no done after err", done, 0);
    check("R8 err sticky", buf_err, 1);
    check("R8 word frozen", q_word, 16'h0001);

    // R5: strobe only in the clock-low phase
    do_reset();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 16'hBEEF);
    next_cycle();
    drive(1'b1, 1'b0, 1'b0, 2'b00, 16'h0000);
    check("R3 first read after trigger", q_word, 16'hBEEF);
    check("R5 strobe low phase", q_strobe, 1);
    @(posedge clk); #1;
    check("R5 strobe high phase", q_strobe, 0);
    next_cycle();
    check("R5 strobe ends with valid", q_strobe, 0);

    // R10: back-to-back retrigger elements, then pulse ends
    drive(1'b1, 1'b1, 1'b0, 2'b11, 16'h1111);
    next_cycle();
    check("R10 pulse", retrig_pulse, 1);
    drive(1'b1, 1'b0, 1'b0, 2'b11, 16'h1111);
    next_cycle();
    check("R10 single cycle", retrig_pulse, 0);
    check("R10 word kept", q_word, 16'hBEEF);

    // R11: reset mid-stream clears terminal flags
    drive(1'b1, 1'b1, 1'b0, 2'b10, '0);
    next_cycle();
    check("R6 done", done, 1);
    init_value = 16'h00C3;
    do_reset();
    check("R11 done cleared", done, 0);
    check("R11 preset after reset", q_word, 16'h00C3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule